// File: doc/BRIEF.md
# Round-Robin Channel Transmit Scheduler

This block shares one tagged transmit FIFO among sixteen per-channel byte queues. It keeps a pending byte count for every channel and a total over all of them. A rotating pointer names the channel that is looked at first. When data is pending and the FIFO has room, the scheduler picks the nearest channel with data at or after the pointer. It asks an external packer for one word from that channel, and pushes the word into the FIFO tagged with the channel number. The pointer then moves past the channel that was served, so a busy channel cannot starve the others.

The byte storage and the packing of bytes into words sit outside the block. Writers report bytes added to a queue through the add port. The packer answers a request with a grant, a 32-bit word and the number of bytes that word consumed. When the FIFO is full the scheduler parks in a waiting state and raises a request for a not-full interrupt. A per-channel reset pulse and drained flag report queues that have emptied. A flush request lets software wait for one channel to empty while the other channels are served as usual.

Top module: `chan_tx_scheduler`

## Requirements
- R1: After synchronous reset the pointer is 0, every drained flag is 1, every queue reset pulse is 0, and neither `pk_req` nor `tx_irq_req` is asserted.
- R2: While the total pending count is zero, `pk_req` stays low and nothing is pushed.
- R3: The channel served is the first channel with a nonzero count found by stepping upward from the pointer, wrapping from 15 to 0. Empty channels are passed over.
- R4: After a word from channel c is pushed, the pointer becomes c+1, or 0 when c is 15. A channel that still has data is served again only after every other channel with data has had a turn.
- R5: The block issues one word per grant. `fifo_push` equals `pk_req & pk_gnt`, `fifo_word` carries `pk_word`, and `fifo_tag` carries the channel. `pk_bytes` (1 to 4) is subtracted from that channel's count and from the total at the same clock edge.
- R6: Nothing is pushed while `fifo_full` is high. When data is pending and the FIFO is full, `tx_irq_req` (the waiting flag) rises. Once `fifo_full` falls, the flag drops and service resumes.
- R7: When a push brings a channel's count to zero, that channel's `q_reset` bit pulses high for exactly the following cycle.
- R8: `drained[c]` is high exactly when channel c's count is zero. It is registered, so it follows the count at the same edge that updates the count.
- R9: A flush on a channel forces its drained flag low for the cycle after the request. While that channel's count is nonzero its flag stays low, and other channels keep being scheduled and can drain first.
- R10: An add and a push on the same channel at the same edge give a count of old + added − consumed, and no drain event fires unless that result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_valid | input | 1 | Bytes were appended to a channel queue |
| add_chan | input | 4 | Channel receiving the bytes |
| add_len | input | 8 | Number of bytes appended |
| flush_valid | input | 1 | Flush request |
| flush_chan | input | 4 | Channel being flushed |
| pk_req | output | 1 | Request one word from the packer |
| pk_chan | output | 4 | Channel the packer should read |
| pk_gnt | input | 1 | Packer delivers a word this cycle |
| pk_word | input | 32 | Packed word |
| pk_bytes | input | 3 | Bytes consumed by the word (1..4) |
| fifo_full | input | 1 | Shared transmit FIFO is full |
| fifo_push | output | 1 | Write strobe into the FIFO |
| fifo_word | output | 32 | Word written into the FIFO |
| fifo_tag | output | 4 | Channel tag written with the word |
| tx_irq_req | output | 1 | Waiting flag; asks for the not-full interrupt |
| q_reset | output | 16 | One-cycle pulse: reset that queue's pointers |
| drained | output | 16 | Channel has no pending bytes |

## Verification
The bench sweeps the starting pointer position over all sixteen values with sparse channel sets that wrap past channel 15. It compares the exact tag order with an arithmetic round-robin model. A design that advanced the pointer past skipped empty channels, or that restarted the search at 0, would give a different order. FIFO-full and grant stalls are mixed into the stream. Any push made while the FIFO is full, or a waiting flag that does not drop, is reported. Drained flags and reset pulses are compared every cycle against counts the bench keeps itself, and adds land on a channel in the same cycle as its pushes. Lost subtractions or a flush that never lowers the flag of an empty channel therefore show up.

// File: rtl/chan_sched_pkg.sv
package chan_sched_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    // Next channel index after idx, wrapping at n.
    function automatic int chan_wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [CH_W-1:0]   ptr,
    input  logic [NUM_CH-1:0] busy,
    output logic              found,
    output logic [CH_W-1:0]   pick
);
    // Walk offsets from the far end back to the pointer so the
    // nearest busy channel is the last one written.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= NUM_CH) idx = idx - NUM_CH;
            if (busy[idx]) begin
                found = 1'b1;
                pick  = CH_W'(idx);
            end
        end
    end
endmodule

// File: rtl/chan_ledger.sv
module chan_ledger #(
    parameter int NUM_CH  = 16,
    parameter int CNT_W   = 8,
    parameter int BYTES_W = 3,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int TOT_W = CNT_W + CH_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               add_valid,
    input  logic [CH_W-1:0]    add_chan,
    input  logic [CNT_W-1:0]   add_len,
    input  logic               flush_valid,
    input  logic [CH_W-1:0]    flush_chan,
    input  logic               dec_valid,
    input  logic [CH_W-1:0]    dec_chan,
    input  logic [BYTES_W-1:0] dec_bytes,
    output logic [NUM_CH-1:0]  busy,
    output logic               tot_zero,
    output logic [NUM_CH-1:0]  q_reset,
    output logic [NUM_CH-1:0]  drained
);
    logic [TOT_W-1:0] tot_q;
    logic [TOT_W-1:0] tot_nx;

    always_comb begin
        tot_nx = tot_q;
        if (add_valid) tot_nx = tot_nx + TOT_W'(add_len);
        if (dec_valid) tot_nx = tot_nx - TOT_W'(dec_bytes);
    end

    always_ff @(posedge clk) begin
        if (rst) tot_q <= '0;
        else     tot_q <= tot_nx;
    end

    assign tot_zero = (tot_q == '0);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic             add_hit, dec_hit, flush_hit;
            logic [CNT_W-1:0] cnt_r, cnt_nx;
            logic             qr_r, dr_r;

            always_comb begin
                add_hit   = add_valid   && (add_chan   == CH_W'(g));
                dec_hit   = dec_valid   && (dec_chan   == CH_W'(g));
                flush_hit = flush_valid && (flush_chan == CH_W'(g));
                cnt_nx    = cnt_r;
                if (add_hit) cnt_nx = cnt_nx + add_len;
                if (dec_hit) cnt_nx = cnt_nx - CNT_W'(dec_bytes);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_r <= '0;
                    qr_r  <= 1'b0;
                    dr_r  <= 1'b1;
                end else begin
                    cnt_r <= cnt_nx;
                    qr_r  <= dec_hit && (cnt_nx == '0);
                    dr_r  <= (cnt_nx == '0) && !flush_hit;
                end
            end

            assign busy[g]    = (cnt_r != '0);
            assign q_reset[g] = qr_r;
            assign drained[g] = dr_r;

            // R5: the packer never consumes more than is pending
            assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
                dec_hit |-> (CNT_W'(dec_bytes) <= cnt_r))
                else $error("channel consumed beyond its pending count");

            // R7: a reset pulse leaves the channel empty
            assert_reset_empty_R7: assert property (@(posedge clk) disable iff (rst)
                qr_r |-> !busy[g])
                else $error("queue reset with bytes still pending");
        end
    endgenerate

    // R5: total and per-channel counts stay in agreement
    assert_total_agrees_R5: assert property (@(posedge clk) disable iff (rst)
        (tot_q == '0) == (busy == '0))
        else $error("total count disagrees with channel counts");

    // R7: at most one queue drains per cycle
    assert_single_drain_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_reset))
        else $error("more than one drain event in a cycle");
endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
    import chan_sched_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int WORD_W  = 32,
    parameter int BYTES_W = 3,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tot_zero,
    input  logic               found,
    input  logic [CH_W-1:0]    pick,
    input  logic               fifo_full,
    input  logic               pk_gnt,
    input  logic [WORD_W-1:0]  pk_word,
    input  logic [BYTES_W-1:0] pk_bytes,
    output logic [CH_W-1:0]    ptr,
    output logic               pk_req,
    output logic [CH_W-1:0]    pk_chan,
    output logic               fifo_push,
    output logic [WORD_W-1:0]  fifo_word,
    output logic [CH_W-1:0]    fifo_tag,
    output logic               tx_irq_req,
    output logic               dec_valid,
    output logic [CH_W-1:0]    dec_chan,
    output logic [BYTES_W-1:0] dec_bytes
);
    sq_state_e        state_q;
    logic [CH_W-1:0]  sel_q;
    logic [CH_W-1:0]  ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            sel_q   <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (!tot_zero) begin
                        if (fifo_full) begin
                            state_q <= SQ_WAIT;
                        end else if (found) begin
                            sel_q   <= pick;
                            state_q <= SQ_REQ;
                        end
                    end
                end
                SQ_REQ: begin
                    if (fifo_full) begin
                        state_q <= SQ_WAIT;
                    end else if (pk_gnt) begin
                        state_q <= SQ_IDLE;
                        if (pk_bytes != '0)
                            ptr_q <= CH_W'(chan_wrap_inc(int'(sel_q), NUM_CH));
                    end
                end
                SQ_WAIT: begin
                    if (!fifo_full) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign ptr        = ptr_q;
    assign pk_chan    = sel_q;
    assign pk_req     = (state_q == SQ_REQ) && !fifo_full;
    assign fifo_push  = pk_req && pk_gnt;
    assign fifo_word  = pk_word;
    assign fifo_tag   = sel_q;
    assign tx_irq_req = (state_q == SQ_WAIT);
    assign dec_valid  = fifo_push;
    assign dec_chan   = sel_q;
    assign dec_bytes  = pk_bytes;

    // R2: no request while nothing is pending
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        tot_zero |-> !pk_req)
        else $error("packer request with nothing pending");

    // R4: pointer moves just past the served channel
    assert_ptr_follows_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> (ptr_q == CH_W'(chan_wrap_inc(int'($past(pk_chan)), NUM_CH))))
        else $error("pointer did not move past served channel");

    // R5: every granted word consumes between one and four bytes
    assert_bytes_legal_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> (pk_bytes != '0 && pk_bytes <= BYTES_W'(4)))
        else $error("illegal byte count from packer");

    // R6: pending data against a full FIFO raises the waiting flag
    assert_wait_on_full_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && !tot_zero && fifo_full) |=> tx_irq_req)
        else $error("waiting flag not raised on full FIFO");

    // R6: the waiting flag drops once room appears
    assert_wait_release_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_irq_req && !fifo_full) |=> !tx_irq_req)
        else $error("waiting flag held after FIFO left full");
endmodule

// File: rtl/chan_tx_scheduler.sv
module chan_tx_scheduler
    import chan_sched_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int CNT_W   = 8,
    parameter int WORD_W  = 32,
    parameter int BYTES_W = 3,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               add_valid,
    input  logic [CH_W-1:0]    add_chan,
    input  logic [CNT_W-1:0]   add_len,
    input  logic               flush_valid,
    input  logic [CH_W-1:0]    flush_chan,
    output logic               pk_req,
    output logic [CH_W-1:0]    pk_chan,
    input  logic               pk_gnt,
    input  logic [WORD_W-1:0]  pk_word,
    input  logic [BYTES_W-1:0] pk_bytes,
    input  logic               fifo_full,
    output logic               fifo_push,
    output logic [WORD_W-1:0]  fifo_word,
    output logic [CH_W-1:0]    fifo_tag,
    output logic               tx_irq_req,
    output logic [NUM_CH-1:0]  q_reset,
    output logic [NUM_CH-1:0]  drained
);
    logic [NUM_CH-1:0]  busy;
    logic               tot_zero;
    logic               found;
    logic [CH_W-1:0]    pick;
    logic [CH_W-1:0]    ptr;
    logic               dec_valid;
    logic [CH_W-1:0]    dec_chan;
    logic [BYTES_W-1:0] dec_bytes;

    chan_ledger #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .BYTES_W(BYTES_W)
    ) u_ledger (
        .clk        (clk),
        .rst        (rst),
        .add_valid  (add_valid),
        .add_chan   (add_chan),
        .add_len    (add_len),
        .flush_valid(flush_valid),
        .flush_chan (flush_chan),
        .dec_valid  (dec_valid),
        .dec_chan   (dec_chan),
        .dec_bytes  (dec_bytes),
        .busy       (busy),
        .tot_zero   (tot_zero),
        .q_reset    (q_reset),
        .drained    (drained)
    );

    rr_picker #(
        .NUM_CH(NUM_CH)
    ) u_picker (
        .ptr  (ptr),
        .busy (busy),
        .found(found),
        .pick (pick)
    );

    tx_sequencer #(
        .NUM_CH (NUM_CH),
        .WORD_W (WORD_W),
        .BYTES_W(BYTES_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tot_zero  (tot_zero),
        .found     (found),
        .pick      (pick),
        .fifo_full (fifo_full),
        .pk_gnt    (pk_gnt),
        .pk_word   (pk_word),
        .pk_bytes  (pk_bytes),
        .ptr       (ptr),
        .pk_req    (pk_req),
        .pk_chan   (pk_chan),
        .fifo_push (fifo_push),
        .fifo_word (fifo_word),
        .fifo_tag  (fifo_tag),
        .tx_irq_req(tx_irq_req),
        .dec_valid (dec_valid),
        .dec_chan  (dec_chan),
        .dec_bytes (dec_bytes)
    );

    // R3: the served channel always had data when it was chosen
    assert_pick_busy_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> busy[pk_chan])
        else $error("word pushed for an empty channel");

    // R6: no write into a full FIFO
    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_full)
        else $error("push while FIFO full");
endmodule

// File: tb/tb_chan_tx_scheduler.sv
module tb_chan_tx_scheduler;
    localparam int NUM_CH  = 16;
    localparam int CH_W    = 4;
    localparam int CNT_W   = 8;
    localparam int WORD_W  = 32;
    localparam int BYTES_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              add_valid = 1'b0;
    logic [CH_W-1:0]   add_chan  = '0;
    logic [CNT_W-1:0]  add_len   = '0;
    logic              flush_valid = 1'b0;
    logic [CH_W-1:0]   flush_chan  = '0;
    logic              pk_req;
    logic [CH_W-1:0]   pk_chan;
    logic              pk_gnt;
    logic [WORD_W-1:0] pk_word;
    logic [BYTES_W-1:0] pk_bytes;
    logic              fifo_full;
    logic              fifo_push;
    logic [WORD_W-1:0] fifo_word;
    logic [CH_W-1:0]   fifo_tag;
    logic              tx_irq_req;
    logic [NUM_CH-1:0] q_reset;
    logic [NUM_CH-1:0] drained;

    logic full_hold  = 1'b0;
    logic stall_mode = 1'b0;
    int   scnt = 0;

    int mrem [NUM_CH];
    bit fprev[NUM_CH];
    bit qexp [NUM_CH];
    int log_tag[4096];
    int log_n = 0;

    int n_chk = 0, n_fail = 0;
    int dr_err = 0, qr_err = 0, push_full_err = 0, word_err = 0;
    int bytes_in = 0, bytes_out = 0, req_cnt = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int mptr = 0;

    always #4 clk = ~clk;   // 125 MHz

    chan_tx_scheduler dut (
        .clk(clk), .rst(rst),
        .add_valid(add_valid), .add_chan(add_chan), .add_len(add_len),
        .flush_valid(flush_valid), .flush_chan(flush_chan),
        .pk_req(pk_req), .pk_chan(pk_chan), .pk_gnt(pk_gnt),
        .pk_word(pk_word), .pk_bytes(pk_bytes),
        .fifo_full(fifo_full), .fifo_push(fifo_push),
        .fifo_word(fifo_word), .fifo_tag(fifo_tag),
        .tx_irq_req(tx_irq_req), .q_reset(q_reset), .drained(drained)
    );

    // Stall patterns, FIFO model and packer model
    always @(negedge clk) scnt <= scnt + 1;
    assign fifo_full = full_hold | (stall_mode & ((scnt % 7) >= 5));
    assign pk_gnt    = pk_req & ~(stall_mode & ((scnt % 3) == 1));
    assign pk_bytes  = BYTES_W'((mrem[pk_chan] > 4) ? 4 : mrem[pk_chan]);
    assign pk_word   = {16'hC0DE, 12'h000, pk_chan};

    // Bench-side pending counts, following the requirements
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                mrem[i]  <= 0;
                fprev[i] <= 1'b0;
                qexp[i]  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                int nx;
                nx = mrem[i];
                if (add_valid && int'(add_chan) == i) nx = nx + int'(add_len);
                if (fifo_push && int'(fifo_tag) == i) nx = nx - int'(pk_bytes);
                mrem[i]  <= nx;
                qexp[i]  <= fifo_push && int'(fifo_tag) == i && nx == 0;
                fprev[i] <= flush_valid && int'(flush_chan) == i;
            end
        end
    end

    // Monitor, sampled just after the falling edge
    always @(negedge clk) begin
        #1;
        if (mon_en) begin
            if (fifo_push) begin
                if (fifo_full) push_full_err++;
                if (fifo_word != {16'hC0DE, 12'h000, fifo_tag}) word_err++;
                if (log_n < 4096) begin
                    log_tag[log_n] = int'(fifo_tag);
                    log_n++;
                end
                bytes_out += int'(pk_bytes);
            end
            if (pk_req) req_cnt++;
            for (int i = 0; i < NUM_CH; i++) begin
                if (drained[i] != (mrem[i] == 0 && !fprev[i])) dr_err++;   // R8, R9
                if (q_reset[i] != qexp[i]) qr_err++;                        // R7
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic add_bytes(input int ch, input int len);
        add_valid = 1'b1;
        add_chan  = CH_W'(ch);
        add_len   = CNT_W'(len);
        bytes_in += len;
        @(negedge clk);
        add_valid = 1'b0;
    endtask

    function automatic bit all_zero();
        for (int i = 0; i < NUM_CH; i++) if (mrem[i] != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic wait_drain();
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (all_zero()) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_pattern(input int lens[NUM_CH], input bit stall);
        int  exp_seq[512];
        int  rem[NUM_CH];
        int  n, start, p, bad_k, act_b, exp_b;
        bit  pending;
        full_hold = 1'b1;
        pending = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (lens[ch] > 0) begin
                add_bytes(ch, lens[ch]);
                pending = 1'b1;
            end
        end
        repeat (3) @(negedge clk);
        if (pending)
            chk(tx_irq_req == 1'b1, "R6", "waiting flag while full", int'(tx_irq_req), 1);
        // round-robin reference: search from pointer, 4 bytes per word max
        for (int i = 0; i < NUM_CH; i++) rem[i] = lens[i];
        p = mptr;
        n = 0;
        forever begin
            int c;
            c = -1;
            for (int k = 0; k < NUM_CH; k++) begin
                int idx;
                idx = (p + k) % NUM_CH;
                if (c < 0 && rem[idx] > 0) c = idx;
            end
            if (c < 0) break;
            exp_seq[n] = c;
            n++;
            rem[c] = rem[c] - ((rem[c] > 4) ? 4 : rem[c]);
            p = (c + 1) % NUM_CH;
        end
        start = log_n;
        stall_mode = stall;
        full_hold  = 1'b0;
        wait_drain();
        stall_mode = 1'b0;
        mptr = p;
        chk(log_n - start == n, "R4", "words pushed in pattern", log_n - start, n);
        bad_k = -1; act_b = 0; exp_b = 0;
        for (int k = 0; k < n && k < log_n - start; k++) begin
            if (bad_k < 0 && log_tag[start + k] != exp_seq[k]) begin
                bad_k = k;
                act_b = log_tag[start + k];
                exp_b = exp_seq[k];
            end
        end
        chk(bad_k < 0, "R3", "service order tag", act_b, exp_b);
        chk(tx_irq_req == 1'b0, "R6", "waiting flag after full cleared", int'(tx_irq_req), 0);
    endtask

    initial begin
        int lens[NUM_CH];
        int r0, o0;
        bit saw_other;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;
        // R1: reset state
        chk(drained == '1, "R1", "drained after reset", int'(drained), 16'hFFFF);
        chk(q_reset == '0, "R1", "q_reset after reset", int'(q_reset), 0);
        chk(pk_req == 1'b0 && tx_irq_req == 1'b0, "R1", "req/irq after reset",
            int'({pk_req, tx_irq_req}), 0);

        // R2: quiet while nothing pending
        r0 = req_cnt;
        repeat (20) @(negedge clk);
        chk(req_cnt == r0 && log_n == 0, "R2", "requests while idle", req_cnt - r0, 0);

        // Every channel loaded, some needing two words (R3, R4)
        for (int c = 0; c < NUM_CH; c++) lens[c] = (c % 7) + 1;
        run_pattern(lens, 1'b0);

        // Sweep of sparse sets rotating around the ring, stalls on odd steps
        for (int s = 0; s < NUM_CH; s++) begin
            for (int c = 0; c < NUM_CH; c++) lens[c] = 0;
            lens[s] = 6;
            lens[(s + 5) % NUM_CH] = 3;
            lens[(s + 11) % NUM_CH] = 9;
            run_pattern(lens, s[0]);
        end

        // Single channel at the top of the ring: served back to back, wraps
        for (int c = 0; c < NUM_CH; c++) lens[c] = 0;
        lens[15] = 13;
        run_pattern(lens, 1'b0);
        lens[15] = 0;
        lens[0] = 2;
        lens[9] = 5;
        run_pattern(lens, 1'b1);

        // R9: flush
        full_hold = 1'b1;
        add_bytes(3, 9);
        add_bytes(7, 2);
        flush_valid = 1'b1;
        flush_chan  = CH_W'(12);
        @(negedge clk);
        flush_valid = 1'b0;
        chk(drained[12] == 1'b0, "R9", "flush on empty channel lowers flag", int'(drained[12]), 0);
        @(negedge clk);
        chk(drained[12] == 1'b1, "R9", "empty channel flag back after flush", int'(drained[12]), 1);
        flush_valid = 1'b1;
        flush_chan  = CH_W'(3);
        @(negedge clk);
        flush_valid = 1'b0;
        chk(drained[3] == 1'b0, "R9", "flushed channel with data", int'(drained[3]), 0);
        full_hold = 1'b0;
        saw_other = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (drained[7] && !drained[3]) saw_other = 1'b1;
            if (all_zero()) break;
        end
        repeat (4) @(negedge clk);
        chk(saw_other, "R9", "other channel drained during flush", int'(saw_other), 1);
        chk(drained[3] == 1'b1, "R9", "flushed channel drained at end", int'(drained[3]), 1);
        mptr = (log_tag[log_n - 1] + 1) % NUM_CH;

        // R10: adds landing on a channel while it is being served
        o0 = bytes_out;
        add_bytes(4, 4);
        for (int k = 0; k < 8; k++) add_bytes(4, 1);
        wait_drain();
        chk(bytes_out - o0 == 12, "R10", "bytes sent with concurrent adds", bytes_out - o0, 12);
        chk(drained[4] == 1'b1, "R10", "channel drained after concurrent adds", int'(drained[4]), 1);

        // Whole-run observations
        chk(push_full_err == 0, "R6", "pushes while full", push_full_err, 0);
        chk(word_err == 0, "R5", "word/tag mismatches", word_err, 0);
        chk(bytes_out == bytes_in, "R5", "bytes sent vs added", bytes_out, bytes_in);
        chk(qr_err == 0, "R7", "queue reset pulse mismatches", qr_err, 0);
        chk(dr_err == 0, "R8", "drained flag mismatches", dr_err, 0);
        r0 = req_cnt;
        repeat (20) @(negedge clk);
        chk(req_cnt == r0, "R2", "requests after everything drained", req_cnt - r0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule